// File: doc/BRIEF.md
# Paged Address Translator with Associative Cache

This block turns a logical address into a physical address for a memory divided into fixed-size pages. The low `OFF_W` bits of the address are the offset within a page and pass through unchanged. The high bits form the page number, which is replaced by a frame number. A small fully associative cache of recent translations is searched in parallel. Each cache entry is tagged with a page number and an address-space identifier. A request that hits is answered on the next clock.

On a miss, the page number is first checked against a table-length register. If it is in range, one page-table word is read from memory at the table base plus the page number. A valid word is installed in the cache and its frame is returned. Out-of-range pages and pages marked invalid are answered with a fault code, and nothing is installed. Only one table read is in flight at any time, and no new request is taken while it is pending.

Software-facing inputs set the table base, the table length and the identifier of the running process. Two flush inputs are provided: one drops every cached translation, the other drops only those of one identifier.

Top module: `pt_xlate`

## Requirements
- R1: A request whose page number and current identifier match a valid cache entry is answered with `rsp_valid` high for exactly one cycle, on the clock after acceptance. The answer has `rsp_code` 0 and `rsp_paddr` = {cached frame, unchanged offset}.
- R2: A cache entry only hits when both its page number and its identifier equal the request's page number and the current identifier. A translation cached for one identifier is a miss for another.
- R3: When a miss has a page number greater than or equal to the length register, the block answers on the next clock with `rsp_code` 1 and `rsp_paddr` 0. It issues no memory read and installs nothing.
- R4: An in-range miss raises `mem_rd_valid` with `mem_rd_addr` = base + page number. The address is held until `mem_rd_done`. `req_ready` stays low and requests are ignored meanwhile. The answer comes on the clock after `mem_rd_done`.
- R5: A page-table word holds the frame number in bits [PFN_W-1:0] and a valid bit at bit PFN_W. If the valid bit is 0, the answer is `rsp_code` 2 with `rsp_paddr` 0, and nothing is installed, so a repeat of the same request reads memory again.
- R6: A valid page-table word is installed under the current identifier and its frame is returned with `rsp_code` 0. A repeat of that request then hits without a memory read.
- R7: Installs go to the lowest-numbered empty entry. When no entry is empty, a round-robin pointer picks the victim. The pointer starts at entry 0 and advances only when it is used.
- R8: `flush_all` invalidates every cache entry.
- R9: `flush_asid` invalidates only the entries whose identifier equals `flush_id`.
- R10: After reset, `req_ready` is high and neither `rsp_valid` nor `mem_rd_valid` is high. The cache is empty and the length register is 0, so every request faults with code 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | VA_W | Logical address |
| req_ready | output | 1 | High when a request can be taken |
| rsp_valid | output | 1 | Answer strobe, one cycle |
| rsp_paddr | output | PFN_W+OFF_W | Physical address, 0 on fault |
| rsp_code | output | 2 | 0 ok, 1 length fault, 2 invalid page |
| mem_rd_valid | output | 1 | Page-table read pending |
| mem_rd_addr | output | MA_W | Page-table word address |
| mem_rd_done | input | 1 | Read data present |
| mem_rd_data | input | PFN_W+1 | Page-table word {valid, frame} |
| cfg_base_we | input | 1 | Write table base |
| cfg_base | input | MA_W | Table base value |
| cfg_len_we | input | 1 | Write table length |
| cfg_len | input | VA_W-OFF_W+1 | Table length in entries |
| cfg_asid_we | input | 1 | Write current identifier |
| cfg_asid | input | ASID_W | Current identifier value |
| flush_all | input | 1 | Invalidate all entries |
| flush_asid | input | 1 | Invalidate entries of one identifier |
| flush_id | input | ASID_W | Identifier to invalidate |

## Verification
Assertions check a few rules on every cycle:
- at most one entry matches a request;
- a hit or a length fault is answered on the next clock, and a length fault never starts a read;
- the read address holds steady while a read is pending, and no request is accepted then;
- an invalid word always produces code 2.

Some behaviour can only be shown by the bench's scenarios. These cover the exact frame and offset returned, the identifier separation, whether a refill was kept or not, the order of victims under round-robin replacement, and the selective effect of the two flushes. The bench observes these by counting memory reads and by comparing the answers against a model of the page table.

// File: rtl/pt_xlate.sv
module pt_xlate #(
  parameter int VA_W    = 16,
  parameter int OFF_W   = 8,
  parameter int PFN_W   = 8,
  parameter int ASID_W  = 4,
  parameter int MA_W    = 16,
  parameter int ENTRIES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [VA_W-1:0]        req_vaddr,
  output logic                   req_ready,
  output logic                   rsp_valid,
  output logic [PFN_W+OFF_W-1:0] rsp_paddr,
  output logic [1:0]             rsp_code,
  output logic                   mem_rd_valid,
  output logic [MA_W-1:0]        mem_rd_addr,
  input  logic                   mem_rd_done,
  input  logic [PFN_W:0]         mem_rd_data,
  input  logic                   cfg_base_we,
  input  logic [MA_W-1:0]        cfg_base,
  input  logic                   cfg_len_we,
  input  logic [VA_W-OFF_W:0]    cfg_len,
  input  logic                   cfg_asid_we,
  input  logic [ASID_W-1:0]      cfg_asid,
  input  logic                   flush_all,
  input  logic                   flush_asid,
  input  logic [ASID_W-1:0]      flush_id
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PA_W  = PFN_W + OFF_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] e_vld;
  logic [VPN_W-1:0]   e_vpn  [ENTRIES];
  logic [ASID_W-1:0]  e_asid [ENTRIES];
  logic [PFN_W-1:0]   e_pfn  [ENTRIES];

  logic [MA_W-1:0]    base_q;
  logic [VPN_W:0]     len_q;
  logic [ASID_W-1:0]  asid_q;
  logic               busy;
  logic [VPN_W-1:0]   pend_vpn;
  logic [OFF_W-1:0]   pend_off;
  logic [IDX_W-1:0]   rr;

  wire [VPN_W-1:0] req_vpn = req_vaddr[VA_W-1:OFF_W];
  wire [OFF_W-1:0] req_off = req_vaddr[OFF_W-1:0];
  wire             accept  = req_valid && !busy;
  wire             len_bad = {1'b0, req_vpn} >= len_q;
  wire             fill_ok = busy && mem_rd_done && mem_rd_data[PFN_W];

  logic [ENTRIES-1:0] hit_vec;
  logic [PFN_W-1:0]   hit_pfn;
  logic [IDX_W-1:0]   victim;
  logic               has_free;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    assign hit_vec[g] = e_vld[g] && e_vpn[g] == req_vpn && e_asid[g] == asid_q;
  end

  always_comb begin
    hit_pfn  = '0;
    victim   = rr;
    has_free = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) hit_pfn = hit_pfn | e_pfn[i];
      if (!e_vld[i] && !has_free) begin
        victim   = IDX_W'(i);
        has_free = 1'b1;
      end
    end
  end

  assign req_ready    = !busy;
  assign mem_rd_valid = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q      <= '0;
      len_q       <= '0;
      asid_q      <= '0;
      busy        <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_paddr   <= '0;
      rsp_code    <= 2'd0;
      mem_rd_addr <= '0;
      pend_vpn    <= '0;
      pend_off    <= '0;
      rr          <= '0;
      e_vld       <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (cfg_base_we) base_q <= cfg_base;
      if (cfg_len_we)  len_q  <= cfg_len;
      if (cfg_asid_we) asid_q <= cfg_asid;
      if (accept) begin
        if (|hit_vec) begin
          rsp_valid <= 1'b1;
          rsp_code  <= 2'd0;
          rsp_paddr <= {hit_pfn, req_off};
        end else if (len_bad) begin
          rsp_valid <= 1'b1;
          rsp_code  <= 2'd1;
          rsp_paddr <= '0;
        end else begin
          busy        <= 1'b1;
          mem_rd_addr <= base_q + MA_W'(req_vpn);
          pend_vpn    <= req_vpn;
          pend_off    <= req_off;
        end
      end
      if (busy && mem_rd_done) begin
        busy      <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_code  <= mem_rd_data[PFN_W] ? 2'd0 : 2'd2;
        rsp_paddr <= mem_rd_data[PFN_W] ? {mem_rd_data[PFN_W-1:0], pend_off} : '0;
      end
      for (int i = 0; i < ENTRIES; i++)
        if (flush_all || (flush_asid && e_asid[i] == flush_id)) e_vld[i] <= 1'b0;
      if (fill_ok) begin
        e_vld[victim] <= 1'b1;
        if (!has_free) rr <= (rr == IDX_W'(ENTRIES-1)) ? '0 : rr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_ok) begin
      e_vpn[victim]  <= pend_vpn;
      e_asid[victim] <= asid_q;
      e_pfn[victim]  <= mem_rd_data[PFN_W-1:0];
    end
  end

  p_hit_unique_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  p_hit_next_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept && |hit_vec |=> rsp_valid && rsp_code == 2'd0 && !mem_rd_valid);

  p_len_no_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !(|hit_vec) && len_bad |=> rsp_valid && rsp_code == 2'd1 && !mem_rd_valid);

  p_addr_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_done |=> mem_rd_valid && $stable(mem_rd_addr));

  p_no_accept_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> !req_ready);

  p_invalid_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && mem_rd_done && !mem_rd_data[PFN_W] |=> rsp_valid && rsp_code == 2'd2);
endmodule

// File: tb/tb_pt_xlate.sv
`timescale 1ns/1ps
module tb_pt_xlate;
  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0;
  logic [15:0] req_vaddr = 0;
  logic        req_ready, rsp_valid, mem_rd_valid;
  logic [15:0] rsp_paddr, mem_rd_addr;
  logic [1:0]  rsp_code;
  logic        mem_rd_done = 0;
  logic [8:0]  mem_rd_data = 0;
  logic        cfg_base_we = 0, cfg_len_we = 0, cfg_asid_we = 0;
  logic [15:0] cfg_base = 0;
  logic [8:0]  cfg_len = 0;
  logic [3:0]  cfg_asid = 0, flush_id = 0;
  logic        flush_all = 0, flush_asid = 0;
  int errors = 0, checks = 0, reads = 0, lat = 0;
  logic [15:0] last_addr = 0;
  localparam logic [15:0] BASE = 16'h1000;

  always #2 clk = ~clk;

  pt_xlate dut (.*);

  function automatic logic [8:0] pte(input logic [15:0] a);
    pte = {a[2:0] != 3'd7, a[7:0] ^ 8'h5A};
  endfunction

  always @(posedge clk) begin
    mem_rd_done <= 1'b0;
    if (mem_rd_valid && !mem_rd_done) begin
      if (lat == 2) begin
        mem_rd_done <= 1'b1;
        mem_rd_data <= pte(mem_rd_addr);
        last_addr   <= mem_rd_addr;
        reads       <= reads + 1;
        lat         <= 0;
      end else lat <= lat + 1;
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_asid(input logic [3:0] a);
    @(negedge clk); cfg_asid_we = 1; cfg_asid = a;
    @(negedge clk); cfg_asid_we = 0;
  endtask

  task automatic xlate(input logic [15:0] va, input logic [3:0] a, input logic [1:0] code,
                       input logic rd, input string tag);
    int r0, w;
    logic [15:0] exp_pa;
    logic [15:0] exp_addr;
    set_asid(a);
    exp_addr = BASE + {8'h00, va[15:8]};
    exp_pa = (code == 0) ? {pte(exp_addr)[7:0], va[7:0]} : 16'h0;
    r0 = reads;
    req_valid = 1; req_vaddr = va;
    @(negedge clk); req_valid = 0;
    if (!rd) chk(rsp_valid, {tag, " answer next cycle"}, rsp_valid, 1);
    w = 0;
    while (!rsp_valid && w < 50) begin @(negedge clk); w++; end
    chk(rsp_code == code, {tag, " code"}, rsp_code, code);
    chk(rsp_paddr == exp_pa, {tag, " paddr"}, rsp_paddr, exp_pa);
    chk((reads - r0) == int'(rd), {tag, " memory reads"}, reads - r0, rd);
    if (rd) chk(last_addr == exp_addr, {tag, " read address"}, last_addr, exp_addr);
    @(negedge clk);
    chk(!rsp_valid, {tag, " single-cycle answer"}, rsp_valid, 0);
  endtask

  // {asid, code, read, 0, vaddr}
  localparam logic [23:0] VEC [17] = '{
    24'h12_0312, 24'h10_0345, 24'h1A_0707, 24'h1A_0707, 24'h14_1400,
    24'h12_0E10, 24'h10_0EFF, 24'h22_0312, 24'h10_0399, 24'h12_0101,
    24'h12_0202, 24'h12_0303, 24'h12_0E0E, 24'h10_0111, 24'h22_0333,
    24'h12_0122, 24'h10_0344};

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_rd_valid, "R10 reset outputs", {req_ready, rsp_valid, mem_rd_valid}, 3'b100);
    rst_n = 1;
    @(negedge clk);
    xlate(16'h0012, 4'h1, 2'd1, 1'b0, "R10 zero length");
    @(negedge clk);
    cfg_base_we = 1; cfg_base = BASE; cfg_len_we = 1; cfg_len = 9'd16;
    @(negedge clk); cfg_base_we = 0; cfg_len_we = 0;

    // R1 R2 R3 R5 R6 R7 table walk
    for (int i = 0; i < 17; i++)
      xlate(VEC[i][15:0], VEC[i][23:20], VEC[i][19:18], VEC[i][17],
            $sformatf("R1/R2/R3/R5/R6/R7 vec%0d", i));

    // R9 selective flush
    @(negedge clk); flush_asid = 1; flush_id = 4'h2;
    @(negedge clk); flush_asid = 0;
    xlate(16'h0350, 4'h2, 2'd0, 1'b1, "R9 flushed id misses");
    xlate(16'h0351, 4'h1, 2'd0, 1'b0, "R9 other id kept");

    // R8 full flush
    @(negedge clk); flush_all = 1;
    @(negedge clk); flush_all = 0;
    xlate(16'h0352, 4'h1, 2'd0, 1'b1, "R8 flush all");

    // R3 R5 length boundary
    xlate(16'h0F00, 4'h1, 2'd2, 1'b1, "R5 last in-range page invalid");
    xlate(16'h1000, 4'h1, 2'd1, 1'b0, "R3 first out-of-range page");

    // R4 request while busy is ignored
    begin
      int r0;
      r0 = reads;
      @(negedge clk); req_valid = 1; req_vaddr = 16'h0460;
      @(negedge clk); req_vaddr = 16'h0303;
      chk(!req_ready && mem_rd_valid, "R4 busy during read", {req_ready, mem_rd_valid}, 2'b01);
      @(negedge clk); req_valid = 0;
      while (!rsp_valid) @(negedge clk);
      chk(rsp_paddr == {pte(BASE + 16'h4)[7:0], 8'h60}, "R4 miss answer", rsp_paddr, {pte(BASE + 16'h4)[7:0], 8'h60});
      @(negedge clk);
      chk(!rsp_valid && reads - r0 == 1, "R4 ignored request", reads - r0, 1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule